// File: doc/BRIEF.md
# Programmable Pulse-Swallow Frequency Divider

This block is the integer-N feedback divider of a frequency synthesizer. It divides a high-rate input clock by a programmable ratio. The ratio is built from three parts. A dual-modulus prescaler runs with a base of 32 in the low band or 47 in the high band, and can divide by that base or by the base plus one. A program counter decides how many prescaler cycles make up one output period. A swallow counter decides how many of those cycles use the larger modulus. The total ratio is base × P + S, and this covers both bands with one pair of counters at a step of one input cycle.

The prescaler, the counters and the modulus control all run in the input-clock domain. The prescaler's count of input cycles stands in for its output edges. The divided output is a one-cycle pulse, raised in the first input cycle of each new output period.

The P, S and band values are captured together at the same edge that ends a period, and also while reset is held. Software can change them at any time without corrupting the period in progress. The modulus-control signal is brought out so the swallow window can be observed.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `div_out` is 0, the configuration is taken from the ports, and `mod_small` reads 1 exactly when `s_load` is 0.
- R2: With `band_hi`=0 captured and 0 < S < P, the spacing between consecutive `div_out` pulses is 32·P + S input cycles.
- R3: With `band_hi`=1 captured and 0 ≤ S < P, the spacing between consecutive `div_out` pulses is 47·P + S input cycles.
- R4: Within each output period, `mod_small` is 0 (larger modulus) for the first min(S,P)·(base+1) input cycles. It is 1 (smaller modulus) for the rest of the period, and it never returns to 0 before the period ends.
- R5: `p_load`, `s_load` and `band_hi` are sampled only at the edge that ends a period, or while in reset. A change in the middle of a period does not alter that period's length or its `mod_small` pattern.
- R6: `div_out` is high for exactly one input cycle, which is the first cycle of each new period. The first pulse after reset comes N cycles after the first edge with `rst` low.
- R7: When S ≥ P, the whole period runs in the larger modulus, and the spacing is (base+1)·P.
- R8: A captured P of 0 acts as P = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; also preloads the configuration |
| p_load | input | 7 | Program count P (prescaler cycles per output period) |
| s_load | input | 6 | Swallow count S (prescaler cycles at the larger modulus) |
| band_hi | input | 1 | 0: base 32 (32/33), 1: base 47 (47/48) |
| div_out | output | 1 | One-cycle pulse per output period |
| mod_small | output | 1 | 1 when the prescaler uses its smaller modulus |

## Verification
The bench looks for off-by-one errors in the period length. A design that counted P or S one cycle too many or too few would drift from base·P+S by a whole prescaler cycle or by a single input cycle, and the per-clock comparison would catch it at the first pulse. The bench changes the inputs in the middle of a period to catch a divider that captures them early, which would show up as a period of the wrong length. It also covers S ≥ P, P = 0, the two extremes P=127 and P=1, and both bands. These cases expose a swallow counter that wraps below zero, a program counter that sits stuck at zero, and a modulus pattern that flips back to the larger modulus.

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int P_W     = 7,
  parameter int S_W     = 6,
  parameter int LO_BASE = 32,
  parameter int HI_BASE = 47
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] p_load,
  input  logic [S_W-1:0] s_load,
  input  logic           band_hi,
  output logic           div_out,
  output logic           mod_small
);

  localparam int PRE_W = $clog2(HI_BASE + 1) + 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;
  logic [P_W-1:0]   p_cnt;
  logic [P_W-1:0]   p_eff;
  logic [S_W-1:0]   s_cnt;
  logic             hi_q;
  logic             pre_end;
  logic             reload;

  assign mod_small = (s_cnt == '0);
  assign pre_last  = (hi_q ? PRE_W'(HI_BASE) : PRE_W'(LO_BASE)) - PRE_W'(mod_small);
  assign pre_end   = (pre_cnt == pre_last);
  assign reload    = pre_end && (p_cnt <= P_W'(1));
  assign p_eff     = (p_load == '0) ? P_W'(1) : p_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      p_cnt   <= p_eff;
      s_cnt   <= s_load;
      hi_q    <= band_hi;
      div_out <= 1'b0;
    end else begin
      div_out <= reload;
      if (pre_end) begin
        pre_cnt <= '0;
        if (reload) begin
          p_cnt <= p_eff;
          s_cnt <= s_load;
          hi_q  <= band_hi;
        end else begin
          p_cnt <= p_cnt - P_W'(1);
          if (!mod_small) s_cnt <= s_cnt - S_W'(1);
        end
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out); // R6
  AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (rst)
    div_out |-> (pre_cnt == '0)); // R6
  AST_SWALLOW_STAYS_DONE: assert property (@(posedge clk) disable iff (rst)
    (mod_small && !reload) |=> mod_small); // R4
  AST_BAND_HELD: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(hi_q)); // R5
  AST_P_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    p_cnt != '0); // R8
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= pre_last); // R2

endmodule

// File: tb/tb_pulse_swallow_divider.sv
module tb_pulse_swallow_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] p_load = 7'd5;
  logic [5:0] s_load = 6'd3;
  logic       band_hi = 1'b0;
  logic       div_out, mod_small;

  int tests = 0, fails = 0, cycles = 0;
  bit checking = 1'b0, done = 1'b0;

  int m_P, m_S, m_base, m_N, m_sw, m_c;
  bit m_hi, m_pulse, m_rst_seen;

  always #10 clk = ~clk;

  pulse_swallow_divider dut (
    .clk(clk), .rst(rst), .p_load(p_load), .s_load(s_load),
    .band_hi(band_hi), .div_out(div_out), .mod_small(mod_small)
  );

  function automatic void latch_cfg();
    m_P    = (p_load == 0) ? 1 : int'(p_load);
    m_S    = int'(s_load);
    m_hi   = band_hi;
    m_base = m_hi ? 47 : 32;
    m_sw   = (m_S < m_P) ? m_S : m_P;
    m_N    = m_base * m_P + m_sw;
  endfunction

  function automatic string tag();
    string t;
    t = m_hi ? "R3" : "R2";
    if (m_S >= m_P) t = {t, "/R7"};
    if (p_load == 0 || m_P == 1) t = {t, "/R8"};
    return {t, "/R5"};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      latch_cfg();
      m_c = 0;
      m_pulse = 1'b0;
      m_rst_seen = 1'b1;
    end else if (m_rst_seen) begin
      if (m_c == m_N - 1) begin
        latch_cfg();
        m_c = 0;
        m_pulse = 1'b1;
      end else begin
        m_c++;
        m_pulse = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    bit exp_mod;
    cycles++;
    if (checking && m_rst_seen) begin
      exp_mod = (m_c >= m_sw * (m_base + 1));
      tests++;
      if (div_out !== m_pulse) begin
        fails++;
        $display("FAIL %s/R6 div_out actual=%0b expected=%0b (cycle %0d of N=%0d)",
                 tag(), div_out, m_pulse, m_c, m_N);
      end
      tests++;
      if (mod_small !== exp_mod) begin
        fails++;
        $display("FAIL %s/R4 mod_small actual=%0b expected=%0b (cycle %0d of N=%0d)",
                 tag(), mod_small, exp_mod, m_c, m_N);
      end
    end
    if (cycles >= 200000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=<200000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (div_out !== 1'b1) @(negedge clk);
    end
  endtask

  task automatic run_cfg(input int p, input int s, input bit hi, input int n);
    repeat (7) @(negedge clk);
    p_load  = 7'(p);
    s_load  = 6'(s);
    band_hi = hi;
    wait_pulses(n + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checking = 1'b1;
    // R1: reset state with S nonzero, then with S zero
    tests++;
    if (div_out !== 1'b0 || mod_small !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%0b%0b expected=00", div_out, mod_small);
    end
    s_load = 6'd0;
    @(negedge clk);
    tests++;
    if (div_out !== 1'b0 || mod_small !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset actual=%0b%0b expected=01", div_out, mod_small);
    end
    s_load = 6'd3;
    @(negedge clk);
    rst = 1'b0;
    wait_pulses(2);
    run_cfg(5, 3, 1'b1, 2);     // R3: 238
    run_cfg(1, 0, 1'b0, 3);     // R2 boundary P=1: 32
    run_cfg(1, 0, 1'b1, 3);     // R3 boundary: 47
    run_cfg(0, 0, 1'b0, 2);     // R8: P=0 acts as 1
    run_cfg(4, 6, 1'b0, 2);     // R7: 33*4
    run_cfg(3, 3, 1'b1, 2);     // R7: 48*3
    run_cfg(10, 9, 1'b1, 2);    // R3: 479
    run_cfg(127, 63, 1'b1, 2);  // R3 max: 6032
    run_cfg(127, 1, 1'b0, 2);   // R2: 4065
    run_cfg(7, 2, 1'b0, 2);     // R2: 226
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule